// File: doc/BRIEF.md
# Diagnostic Test Output Selector with Clock Bypass

This block drives one slow diagnostic pin. A 3-bit select code chooses what appears on that pin. The choices are a constant high or low level, the serial output of the configuration shift register, half the reference clock, the synthesized output clock, a quarter of that output clock, and the pulse train of the 7-bit feedback counter. The feedback counter lives inside the block so that its output can be watched.

One select code places the block in bypass. The serial programming clock then takes the place of the PLL. The feedback counter advances on rising edges of the serial clock. A bypass flag tells the clock tree to feed the serial clock into the post-divider. The main output then runs at the serial clock rate divided by twice N.

Everything runs in the VCO clock domain. The reference clock, the output clock, the serial clock and the shift-register tap are sampled through synchronizers and used as levels and rising-edge strobes.

Top module: `tsel_top`

## Requirements
- R1: While reset is asserted, `testOut` and `bypassOut` are both 0.
- R2: With select code 3'b001, `testOut` is held at 1. With code 3'b101, it is held at 0.
- R3: With select code 3'b000, `testOut` follows the synchronized level of `shiftTap`.
- R4: With select code 3'b010, `testOut` is the reference clock divided by 2 with a 50% duty cycle. The divider changes state only on a sampled rising edge of `refClk`.
- R5: With select code 3'b011 and no bypass, `testOut` carries the feedback counter output. This is a high pulse one `vcoClk` cycle wide, once every M cycles of `vcoClk`.
- R6: An M value of 0 acts as M = 1. The counter then fires on every enabled cycle, so its output stays high.
- R7: With select code 3'b100, `testOut` follows `foutClk`. With code 3'b111, it shows `foutClk` divided by 4, and that divider changes state only on a sampled rising edge of `foutClk`.
- R8: With select code 3'b110, `bypassOut` becomes 1 and the feedback counter advances only on rising edges of `serClk`. `testOut` then shows a high pulse one serial-clock period wide, once every M serial-clock periods. `bypassOut` rises only after code 3'b110 has been selected.
- R9: `bypassOut` changes only while the synchronized serial clock is low. When `serClk` is held high, a request to enter bypass waits until `serClk` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vcoClk | input | 1 | VCO clock; clocks every register in the block |
| rstN | input | 1 | Asynchronous active-low reset |
| refClk | input | 1 | Reference clock, sampled as a level |
| foutClk | input | 1 | Divided synthesizer output clock, sampled as a level |
| serClk | input | 1 | Serial programming clock; the counter source in bypass |
| shiftTap | input | 1 | Serial output of the 12-bit configuration shift register |
| mVal | input | 7 | Feedback divide value M |
| testSel | input | 3 | Diagnostic select code |
| testOut | output | 1 | Registered diagnostic pin |
| bypassOut | output | 1 | 1 selects the serial clock as the post-divider source |

## Verification
A counter that reloads with the wrong value shows up on the test pin within one M period. The pulse spacing changes, or the pin sticks high or low. That is why each mode is judged by counting high samples and rising edges over a whole number of source periods.

A divider flop that toggles off its source edge changes the duty cycle or rise count within one output period. A bypass flag that switches while the serial clock is high is visible at once at `bypassOut` while the serial clock is held high.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  typedef enum logic [2:0] {
    SEL_SHIFT   = 3'b000,
    SEL_ONE     = 3'b001,
    SEL_REFHALF = 3'b010,
    SEL_MCOUNT  = 3'b011,
    SEL_FOUT    = 3'b100,
    SEL_ZERO    = 3'b101,
    SEL_BYPASS  = 3'b110,
    SEL_FOUTQTR = 3'b111
  } testSel_e;

  typedef struct packed {
    logic refRise;
    logic foutRise;
    logic cntEn;
    logic shiftLvl;
    logic foutLvl;
    logic bypass;
  } strobes_t;

  typedef struct packed {
    logic mPulse;
    logic refHalf;
    logic foutQtr;
  } nodes_t;

endpackage

// File: rtl/tsel_ctl.sv
module tsel_ctl
  import tsel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       vcoClk,
  input  logic       rstN,
  input  logic       refClk,
  input  logic       foutClk,
  input  logic       serClk,
  input  logic       shiftTap,
  input  logic [2:0] testSel,
  output strobes_t   stb
);

  localparam int NSIG  = 4;
  localparam int I_REF = 0;
  localparam int I_FOUT = 1;
  localparam int I_SER = 2;
  localparam int I_SHF = 3;

  logic [NSIG-1:0] rawIn;
  logic [NSIG-1:0] lvl;
  logic [NSIG-1:0] prevLvl;
  logic            bypassQ;
  logic            bypassReq;

  assign rawIn = {shiftTap, serClk, foutClk, refClk};

  for (genvar i = 0; i < NSIG; i++) begin : g_sync
    logic [SYNC_STAGES:0] pipe;
    always_ff @(posedge vcoClk or negedge rstN) begin
      if (!rstN) pipe <= '0;
      else       pipe <= {pipe[SYNC_STAGES-1:0], rawIn[i]};
    end
    assign lvl[i]     = pipe[SYNC_STAGES-1];
    assign prevLvl[i] = pipe[SYNC_STAGES];
  end

  assign bypassReq = (testSel == SEL_BYPASS);

  // Source handover happens only while the serial clock is low
  always_ff @(posedge vcoClk or negedge rstN) begin
    if (!rstN)                                   bypassQ <= 1'b0;
    else if (!lvl[I_SER] && bypassReq != bypassQ) bypassQ <= bypassReq;
  end

  always_comb begin
    stb.refRise  = lvl[I_REF] & ~prevLvl[I_REF];
    stb.foutRise = lvl[I_FOUT] & ~prevLvl[I_FOUT];
    stb.cntEn    = bypassQ ? (lvl[I_SER] & ~prevLvl[I_SER]) : 1'b1;
    stb.shiftLvl = lvl[I_SHF];
    stb.foutLvl  = lvl[I_FOUT];
    stb.bypass   = bypassQ;
  end

endmodule

// File: rtl/tsel_nodes.sv
module tsel_nodes
  import tsel_pkg::*;
#(
  parameter int M_WIDTH       = 7,
  parameter int REF_DIV_LOG2  = 1,
  parameter int FOUT_DIV_LOG2 = 2
) (
  input  logic               vcoClk,
  input  logic               rstN,
  input  logic               refRise,
  input  logic               foutRise,
  input  logic               cntEn,
  input  logic [M_WIDTH-1:0] mVal,
  output nodes_t             nodes
);

  logic [M_WIDTH-1:0]       mEff;
  logic [M_WIDTH-1:0]       cnt;
  logic                     pulse;
  logic [REF_DIV_LOG2-1:0]  refDiv;
  logic [FOUT_DIV_LOG2-1:0] foutDiv;

  assign mEff = (mVal == '0) ? M_WIDTH'(1) : mVal;

  always_ff @(posedge vcoClk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (cntEn) begin
      if (cnt == '0 || cnt >= mEff) begin
        cnt   <= mEff - M_WIDTH'(1);
        pulse <= 1'b1;
      end else begin
        cnt   <= cnt - M_WIDTH'(1);
        pulse <= 1'b0;
      end
    end
  end

  always_ff @(posedge vcoClk or negedge rstN) begin
    if (!rstN)        refDiv <= '0;
    else if (refRise) refDiv <= refDiv + REF_DIV_LOG2'(1);
  end

  always_ff @(posedge vcoClk or negedge rstN) begin
    if (!rstN)         foutDiv <= '0;
    else if (foutRise) foutDiv <= foutDiv + FOUT_DIV_LOG2'(1);
  end

  assign nodes.mPulse  = pulse;
  assign nodes.refHalf = refDiv[REF_DIV_LOG2-1];
  assign nodes.foutQtr = foutDiv[FOUT_DIV_LOG2-1];

endmodule

// File: rtl/tsel_mux.sv
module tsel_mux
  import tsel_pkg::*;
(
  input  logic       vcoClk,
  input  logic       rstN,
  input  logic [2:0] testSel,
  input  logic       shiftLvl,
  input  logic       foutLvl,
  input  nodes_t     nodes,
  output logic       testOut
);

  logic nextOut;

  always_comb begin
    case (testSel_e'(testSel))
      SEL_SHIFT:   nextOut = shiftLvl;
      SEL_ONE:     nextOut = 1'b1;
      SEL_REFHALF: nextOut = nodes.refHalf;
      SEL_MCOUNT:  nextOut = nodes.mPulse;
      SEL_FOUT:    nextOut = foutLvl;
      SEL_ZERO:    nextOut = 1'b0;
      SEL_BYPASS:  nextOut = nodes.mPulse;
      SEL_FOUTQTR: nextOut = nodes.foutQtr;
      default:     nextOut = 1'b0;
    endcase
  end

  always_ff @(posedge vcoClk or negedge rstN) begin
    if (!rstN) testOut <= 1'b0;
    else       testOut <= nextOut;
  end

endmodule

// File: rtl/tsel_top.sv
module tsel_top
  import tsel_pkg::*;
#(
  parameter int M_WIDTH     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               vcoClk,
  input  logic               rstN,
  input  logic               refClk,
  input  logic               foutClk,
  input  logic               serClk,
  input  logic               shiftTap,
  input  logic [M_WIDTH-1:0] mVal,
  input  logic [2:0]         testSel,
  output logic               testOut,
  output logic               bypassOut
);

  strobes_t stb;
  nodes_t   nodes;

  tsel_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .vcoClk(vcoClk), .rstN(rstN), .refClk(refClk), .foutClk(foutClk),
    .serClk(serClk), .shiftTap(shiftTap), .testSel(testSel), .stb(stb)
  );

  tsel_nodes #(.M_WIDTH(M_WIDTH)) u_nodes (
    .vcoClk(vcoClk), .rstN(rstN), .refRise(stb.refRise),
    .foutRise(stb.foutRise), .cntEn(stb.cntEn), .mVal(mVal), .nodes(nodes)
  );

  tsel_mux u_mux (
    .vcoClk(vcoClk), .rstN(rstN), .testSel(testSel), .shiftLvl(stb.shiftLvl),
    .foutLvl(stb.foutLvl), .nodes(nodes), .testOut(testOut)
  );

  assign bypassOut = stb.bypass;

endmodule

// File: rtl/tsel_checker.sv
module tsel_checker #(
  parameter int M_WIDTH = 7
) (
  input logic               vcoClk,
  input logic               rstN,
  input logic               serClk,
  input logic [M_WIDTH-1:0] mVal,
  input logic [2:0]         testSel,
  input logic               testOut,
  input logic               bypassOut,
  input logic               mPulse,
  input logic               refHalf,
  input logic               foutQtr,
  input logic               refRise,
  input logic               foutRise
);

  AST_CONST_ONE: assert property (@(posedge vcoClk) disable iff (!rstN)
    ($past(rstN) && $past(testSel) == 3'b001) |-> testOut);                  // R2

  AST_CONST_ZERO: assert property (@(posedge vcoClk) disable iff (!rstN)
    ($past(rstN) && $past(testSel) == 3'b101) |-> !testOut);                 // R2

  AST_REF_HALF_EDGE: assert property (@(posedge vcoClk) disable iff (!rstN)
    ($past(rstN) && !$stable(refHalf)) |-> $past(refRise));                  // R4

  AST_PULSE_ONE_WIDE: assert property (@(posedge vcoClk) disable iff (!rstN)
    ($past(rstN) && !bypassOut && mVal >= 2 && $stable(mVal) && mPulse)
    |=> !mPulse);                                                            // R5

  AST_FOUT_QTR_EDGE: assert property (@(posedge vcoClk) disable iff (!rstN)
    ($past(rstN) && !$stable(foutQtr)) |-> $past(foutRise));                 // R7

  AST_BYPASS_FROM_CODE: assert property (@(posedge vcoClk) disable iff (!rstN)
    ($past(rstN) && !$past(bypassOut) && bypassOut) |-> $past(testSel) == 3'b110); // R8

  AST_BYPASS_SER_LOW: assert property (@(posedge vcoClk) disable iff (!rstN)
    ($past(rstN, 3) && bypassOut != $past(bypassOut)) |-> !$past(serClk, 3)); // R9

endmodule

bind tsel_top tsel_checker #(.M_WIDTH(M_WIDTH)) u_chk (
  .vcoClk(vcoClk), .rstN(rstN), .serClk(serClk), .mVal(mVal), .testSel(testSel),
  .testOut(testOut), .bypassOut(bypassOut), .mPulse(nodes.mPulse),
  .refHalf(nodes.refHalf), .foutQtr(nodes.foutQtr), .refRise(stb.refRise),
  .foutRise(stb.foutRise)
);

// File: tb/tb_tsel_top.sv
module tb_tsel_top;

  localparam int CLK_PERIOD = 10;
  localparam int REF_P      = 8;
  localparam int FOUT_P     = 6;
  localparam int SER_P      = 10;
  localparam int SETTLE     = 300;
  localparam int WATCHDOG   = 150000;

  logic       vcoClk = 1'b0;
  logic       rstN;
  logic       refClk = 1'b0, foutClk = 1'b0, serClk = 1'b0;
  logic       shiftTap;
  logic [6:0] mVal;
  logic [2:0] testSel;
  logic       testOut, bypassOut;
  logic       serRun = 1'b1, serHold = 1'b0;

  typedef struct {
    int    win;
    int    highs;
    int    rises;
    logic  byp;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   nChecks = 0;
  int   nBad = 0;
  bit   done = 0;

  tsel_top dut (
    .vcoClk(vcoClk), .rstN(rstN), .refClk(refClk), .foutClk(foutClk),
    .serClk(serClk), .shiftTap(shiftTap), .mVal(mVal), .testSel(testSel),
    .testOut(testOut), .bypassOut(bypassOut)
  );

  always #(CLK_PERIOD/2) vcoClk = ~vcoClk;

  initial begin
    int ph = 0;
    forever begin
      @(negedge vcoClk);
      ph = (ph + 1) % REF_P;
      refClk = (ph < REF_P/2);
    end
  end

  initial begin
    int ph = 0;
    forever begin
      @(negedge vcoClk);
      ph = (ph + 1) % FOUT_P;
      foutClk = (ph < FOUT_P/2);
    end
  end

  initial begin
    int ph = 0;
    forever begin
      @(negedge vcoClk);
      if (serRun) begin
        ph = (ph + 1) % SER_P;
        serClk = (ph < SER_P/2);
      end else begin
        serClk = serHold;
      end
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int expv);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Monitor: pops one expected item, observes the window, compares
  initial begin
    forever begin
      exp_t it;
      int h, r, bm;
      logic prev;
      wait (sb.size() > 0);
      it = sb[0];
      h = 0; r = 0; bm = 0;
      prev = testOut;
      repeat (it.win) begin
        @(negedge vcoClk);
        h += int'(testOut);
        if (testOut && !prev) r++;
        prev = testOut;
        if (bypassOut !== it.byp) bm++;
      end
      check(h == it.highs, it.tag, "high samples", h, it.highs);
      check(r == it.rises, it.tag, "rising edges", r, it.rises);
      check(bm == 0, it.tag, "bypass mismatches", bm, 0);
      void'(sb.pop_front());
    end
  end

  // Driver: applies a configuration, lets it settle, pushes the expectation
  task automatic measure(logic [2:0] sel, logic [6:0] m, int win, int h, int r,
                         logic b, string tag);
    @(negedge vcoClk);
    testSel = sel;
    mVal    = m;
    repeat (SETTLE) @(negedge vcoClk);
    sb.push_back('{win, h, r, b, tag});
    wait (sb.size() == 0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge vcoClk);
    if (!done) begin
      done = 1;
      check(1'b0, "watchdog", "run length", WATCHDOG, 0);
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; shiftTap = 1'b0; mVal = 7'd5; testSel = 3'b001;
    repeat (4) @(negedge vcoClk);
    check(testOut == 1'b0, "R1", "testOut in reset", int'(testOut), 0);
    check(bypassOut == 1'b0, "R1", "bypassOut in reset", int'(bypassOut), 0);
    rstN = 1'b1;

    measure(3'b001, 7'd5, 50, 50, 0, 1'b0, "R2 const one");
    measure(3'b101, 7'd5, 50, 0, 0, 1'b0, "R2 const zero");
    shiftTap = 1'b1;
    measure(3'b000, 7'd5, 50, 50, 0, 1'b0, "R3 tap high");
    shiftTap = 1'b0;
    measure(3'b000, 7'd5, 50, 0, 0, 1'b0, "R3 tap low");
    measure(3'b010, 7'd5, 160, 80, 10, 1'b0, "R4 ref half");
    measure(3'b011, 7'd5, 100, 20, 20, 1'b0, "R5 M=5");
    measure(3'b011, 7'd127, 254, 2, 2, 1'b0, "R5 M=127");
    measure(3'b011, 7'd0, 100, 100, 0, 1'b0, "R6 M=0");
    measure(3'b100, 7'd5, 120, 60, 20, 1'b0, "R7 fout");
    measure(3'b111, 7'd5, 240, 120, 10, 1'b0, "R7 fout quarter");
    measure(3'b110, 7'd3, 300, 100, 10, 1'b1, "R8 bypass M=3");
    measure(3'b110, 7'd2, 200, 100, 10, 1'b1, "R8 bypass M=2");
    measure(3'b011, 7'd4, 100, 25, 25, 1'b0, "R8 leave bypass");

    // R9: entry into bypass waits for a low serial clock
    @(negedge vcoClk);
    serHold = 1'b1; serRun = 1'b0;
    repeat (10) @(negedge vcoClk);
    testSel = 3'b110;
    repeat (30) @(negedge vcoClk);
    check(bypassOut == 1'b0, "R9", "bypass while serClk high", int'(bypassOut), 0);
    serHold = 1'b0;
    repeat (10) @(negedge vcoClk);
    check(bypassOut == 1'b1, "R9", "bypass after serClk low", int'(bypassOut), 1);
    serRun = 1'b1;

    repeat (5) @(negedge vcoClk);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

endmodule